// File: doc/BRIEF.md
# Byte-Lane Data Bus Parity Unit

This block sits beside a 64-bit processor data bus that is split into a high 32-bit word and a low 32-bit word. The bus is divided into eight byte lanes. On the write side, it forms one odd-parity bit for each lane. It drives these bits out with the same output-enable that the data lines use, so the parity follows the data on the bus.

On the read side, it samples the returned data and parity only on a cycle where a read is in progress and the transfer-acknowledge strobe is high. It checks all eight lanes on every such cycle, whatever the size of the transfer. When the error-enable configuration bit is set, the first lane with even parity raises a sticky checkstop. The same event captures an eight-bit vector of the failing lanes, which is kept for diagnosis.

Two configuration inputs control the block. One gates parity generation and the other gates error reporting.

Top module: `bus_byte_parity`

## Requirements
- R1: Lane k, for k from 0 to 7, is bits [8k+7:8k] of the concatenation {wr_hi, wr_lo}. So par_out[7] covers wr_hi[31:24] and par_out[0] covers wr_lo[7:0]. When cfg_gen_en is 1, par_out[k] is set so that the count of ones in lane k plus par_out[k] is odd. The bit is combinational from the same-cycle inputs.
- R2: When cfg_gen_en is 0, par_out is all zeros.
- R3: par_oe equals drive_en in every cycle, so parity shares the data output-enable.
- R4: A read lane is checked only in a cycle where rd_active and xfer_ack are both 1. Even parity presented in any other cycle changes neither chk_stop nor lane_err.
- R5: All eight read lanes are checked, using the same lane-to-bit mapping as R1 on {rd_hi, rd_lo} and rd_par. A lane is in error when its 8 data bits plus its parity bit hold an even number of ones.
- R6: A lane error raises chk_stop only when cfg_err_en is 1 in the checked cycle. chk_stop rises on the clock edge that ends that cycle.
- R7: Once set, chk_stop stays at 1 until reset.
- R8: On the edge that sets chk_stop, lane_err takes the vector of failing lanes, with bit k for lane k. It then holds that value while chk_stop is 1. It is zero while chk_stop is 0.
- R9: After reset, chk_stop is 0 and lane_err is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_gen_en | input | 1 | Configuration: parity generation enable |
| cfg_err_en | input | 1 | Configuration: parity error checkstop enable |
| drive_en | input | 1 | Output-enable of the data lines |
| wr_hi | input | 32 | Write data, high word |
| wr_lo | input | 32 | Write data, low word |
| par_out | output | 8 | Generated parity, one bit per lane |
| par_oe | output | 1 | Output-enable for par_out |
| rd_active | input | 1 | A read transaction is in its data phase |
| xfer_ack | input | 1 | Transfer-acknowledge strobe |
| rd_hi | input | 32 | Read data, high word |
| rd_lo | input | 32 | Read data, low word |
| rd_par | input | 8 | Read parity, one bit per lane |
| chk_stop | output | 1 | Sticky checkstop |
| lane_err | output | 8 | Failing-lane vector captured with the checkstop |

## Verification
Write-side parity generation and the read-side check can fall in the same cycle. The bench provokes this by driving fresh write data with generation enabled while it acknowledges a read that carries a bad lane. In the cycle itself, par_out is judged against parity that the bench counts from the write bytes. After the edge, chk_stop and lane_err are judged against the corrupted lane. The bench also sweeps 256 byte patterns through all lanes and injects a single error into each lane in turn.

// File: rtl/bus_byte_parity.sv
module bus_byte_parity #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES = 2 * WORD_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_gen_en,
  input  logic              cfg_err_en,
  input  logic              drive_en,
  input  logic [WORD_W-1:0] wr_hi,
  input  logic [WORD_W-1:0] wr_lo,
  output logic [LANES-1:0]  par_out,
  output logic              par_oe,
  input  logic              rd_active,
  input  logic              xfer_ack,
  input  logic [WORD_W-1:0] rd_hi,
  input  logic [WORD_W-1:0] rd_lo,
  input  logic [LANES-1:0]  rd_par,
  output logic              chk_stop,
  output logic [LANES-1:0]  lane_err
);

  logic [2*WORD_W-1:0] wr_bus, rd_bus;
  logic [LANES-1:0]    gen_bit, bad;
  logic                sample, hit;

  assign wr_bus = {wr_hi, wr_lo};
  assign rd_bus = {rd_hi, rd_lo};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign gen_bit[g] = ~^wr_bus[g*BYTE_W +: BYTE_W];
    assign bad[g]     = ~^{rd_bus[g*BYTE_W +: BYTE_W], rd_par[g]};
  end

  assign par_out = cfg_gen_en ? gen_bit : '0;
  assign par_oe  = drive_en;

  assign sample = rd_active & xfer_ack;
  assign hit    = sample & cfg_err_en & (|bad);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_stop <= 1'b0;
      lane_err <= '0;
    end else if (hit && !chk_stop) begin
      chk_stop <= 1'b1;
      lane_err <= bad;
    end
  end

  p_odd_total_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_gen_en |-> (($countones({wr_bus, par_out}) % 2) == (LANES % 2)));

  p_zero_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_gen_en |-> ($countones(par_out) == 0));

  p_rise_needs_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chk_stop) |-> $past(rd_active && xfer_ack));

  p_rise_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chk_stop) |-> $past(cfg_err_en));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_stop |=> chk_stop);

  p_capture_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chk_stop) |-> (lane_err != '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_stop && $past(chk_stop)) |-> $stable(lane_err));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_stop |-> (lane_err == '0));

endmodule

// File: tb/test_bus_byte_parity.sv
module test_bus_byte_parity;
  logic clk = 0, rst_n = 0;
  logic cfg_gen_en = 0, cfg_err_en = 0, drive_en = 0;
  logic [31:0] wr_hi = 0, wr_lo = 0, rd_hi = 0, rd_lo = 0;
  logic [7:0] rd_par = 0, par_out, lane_err;
  logic par_oe, rd_active = 0, xfer_ack = 0, chk_stop;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_byte_parity i_bus_byte_parity (.*);

  function automatic logic odd_bit(input logic [7:0] b);
    int n = 0;
    for (int i = 0; i < 8; i++) n += b[i];
    return (n % 2 == 0);
  endfunction

  function automatic logic [7:0] good_par(input logic [63:0] d);
    logic [7:0] p;
    for (int k = 0; k < 8; k++) p[k] = odd_bit(d[8*k +: 8]);
    return p;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; rd_active = 0; xfer_ack = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic do_read(input logic [63:0] d, input logic [7:0] p, input logic act, input logic ack);
    @(negedge clk);
    {rd_hi, rd_lo} = d; rd_par = p; rd_active = act; xfer_ack = ack;
    @(negedge clk);
    rd_active = 0; xfer_ack = 0;
  endtask

  initial begin
    logic [63:0] d;
    logic [7:0] exp;
    do_reset();
    chk("R9 chk_stop", chk_stop, 0);
    chk("R9 lane_err", lane_err, 0);

    cfg_gen_en = 1;
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      for (int k = 0; k < 8; k++) d[8*k +: 8] = 8'(v + 37 * k);
      {wr_hi, wr_lo} = d; drive_en = v[0];
      #1;
      for (int k = 0; k < 8; k++) exp[k] = odd_bit(d[8*k +: 8]);
      chk("R1 par_out", par_out, exp);
      chk("R3 par_oe", par_oe, v[0]);
    end
    cfg_gen_en = 0;
    for (int v = 0; v < 16; v++) begin
      @(negedge clk); wr_hi = 32'h0101_0101 * v; wr_lo = ~wr_hi; #1;
      chk("R2 par_out off", par_out, 0);
    end

    cfg_err_en = 1;
    d = 64'h0123_4567_89ab_cdef;
    do_read(d, good_par(d), 1, 1);
    chk("R5 clean read", chk_stop, 0);
    do_read(d, good_par(d) ^ 8'h01, 0, 1);
    chk("R4 ack without read", chk_stop, 0);
    chk("R4 ack without read vec", lane_err, 0);
    do_read(d, good_par(d) ^ 8'h01, 1, 0);
    chk("R4 read without ack", chk_stop, 0);
    cfg_err_en = 0;
    do_read(d, good_par(d) ^ 8'h10, 1, 1);
    chk("R6 disabled", chk_stop, 0);
    chk("R6 disabled vec", lane_err, 0);
    cfg_err_en = 1;

    for (int k = 0; k < 8; k++) begin
      do_reset();
      d = {32'hdead_beef, 32'h0f1e_2d3c} ^ {8{8'(k * 29)}};
      do_read(d, good_par(d) ^ (8'h1 << k), 1, 1);
      chk("R5 lane stop", chk_stop, 1);
      chk("R8 lane vec", lane_err, 8'h1 << k);
    end

    do_reset();
    d = 64'hffff_0000_a5a5_3c3c;
    do_read(d, good_par(d) ^ 8'h42, 1, 1);
    chk("R8 multi lane", lane_err, 8'h42);
    do_read(d, good_par(d), 1, 1);
    chk("R7 sticky", chk_stop, 1);
    do_read(d, good_par(d) ^ 8'h81, 1, 1);
    chk("R8 hold", lane_err, 8'h42);
    repeat (3) @(negedge clk);
    chk("R7 sticky idle", chk_stop, 1);

    do_reset();
    chk("R9 after reset", lane_err, 0);
    @(negedge clk);
    cfg_gen_en = 1; drive_en = 1;
    wr_hi = 32'h8001_7f03; wr_lo = 32'h0000_ffee;
    d = 64'h1111_2222_3333_4444;
    {rd_hi, rd_lo} = d; rd_par = good_par(d) ^ 8'h08; rd_active = 1; xfer_ack = 1;
    #1;
    chk("R1 same cycle gen", par_out, good_par({32'h8001_7f03, 32'h0000_ffee}));
    @(negedge clk);
    rd_active = 0; xfer_ack = 0;
    chk("R6 same cycle stop", chk_stop, 1);
    chk("R8 same cycle vec", lane_err, 8'h08);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule